// File: doc/BRIEF.md
# Real-Time Clock Alarm Matcher and Status Flags

This block sits beside the timekeeping counters of a real-time clock. It compares the current time, given as a set of BCD fields, against one alarm register per field. Each alarm register carries a mask bit, so software can build alarms such as "every minute at second 15" by leaving fields out of the comparison. When all the compared fields match, the block raises an alarm flag.

The block also holds a one-byte status register. It latches watchdog-expiry, power-fail and oscillator-fail events from single-cycle input strobes, and it stores three control bits: calibration mode, time-write freeze and read snapshot. A simple host bus reads and writes the alarm registers and the status byte. Reading the status byte clears the three event flags that clear themselves. The oscillator-fail flag stays set until software writes a 0 to it. When calibration mode is on, the interrupt output carries a square wave made by dividing a 32.768 kHz tick by 64. When it is off, the interrupt output follows the alarm flag.

Top module: `rtc_alarm_flags`

## Requirements
- R1: Host addresses 0 to NUM_FIELDS-1 select the alarm registers. Bit 7 is the mask (1 leaves the field out of the comparison) and bits 6:0 hold the BCD value, which is compared with bits 6:0 of the matching time field. A write to an alarm register takes effect only while the write-enable control bit is 1. A read returns the register on bus_rdata one cycle after bus_rd.
- R2: The alarm flag sets in the cycle after the match condition becomes true. The match condition is true when every unmasked field equals its time field. It sets only once for each continuous match. If all fields are masked, no match happens.
- R3: The status byte sits at address NUM_FIELDS. Its bits are: 7 watchdog, 6 alarm, 5 power-fail, 4 oscillator-fail, 3 always 0, 2 calibration mode, 1 write-enable, 0 read-snapshot.
- R4: A one-cycle pulse on wdog_expired or power_fail sets the matching flag in the next cycle.
- R5: A read of the status byte returns its value from before the read. Afterwards bits 7, 6 and 5 are 0.
- R6: If a set event and a clearing read fall in the same cycle, the flag ends up 1.
- R7: Host writes to bits 7, 6, 5 and 3 of the status byte have no effect.
- R8: A pulse on osc_dead sets bit 4. Reads do not clear it, and writing a 1 to it does not set it. Only a host write with bit 4 equal to 0 clears it.
- R9: After reset, all status bits are 0 and every alarm register reads 0x80 (masked, value 0).
- R10: While calibration mode is 1, irq_out is a square wave that toggles on every 32nd tick_32k pulse and starts low. While calibration mode is 0, irq_out equals the alarm flag.
- R11: time_freeze and time_snap drive out status bits 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| time_now | input | NUM_FIELDS*8 | Current BCD time, field i at bits 8i+7:8i |
| bus_addr | input | AW | Host register address |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| wdog_expired | input | 1 | Watchdog reached zero (pulse) |
| power_fail | input | 1 | Supply fell below threshold (pulse) |
| osc_dead | input | 1 | Oscillator found stopped at power-up (pulse) |
| tick_32k | input | 1 | One-cycle pulse per 32.768 kHz period |
| irq_out | output | 1 | Interrupt output or calibration square wave |
| time_freeze | output | 1 | Write-enable control bit to the time counters |
| time_snap | output | 1 | Read-snapshot control bit to the time counters |

## Verification
The bench goes after a read of the status byte that lands in the same cycle as a watchdog event. A design that lets the clear win loses that event, and the next read shows 0. It holds a match for many cycles and then reads twice. If the flag were level-driven instead of edge-driven, it would show up again right after being cleared. It also checks the case where every field is masked, which a plain AND-reduction would treat as a match that never ends. It tries to clear oscillator-fail by reading and by writing 1, and to write the read-only flags, so that a flag with the wrong clear rule shows up. Finally it counts tick pulses to the exact edge where the calibration wave toggles, which catches an off-by-one in the divider.

// File: rtl/rtcaf_pkg.sv
// Package: shared types and bit positions for the alarm/flags block.
// Assumes 8-bit host data and BCD fields of at most 7 significant bits.
package rtcaf_pkg;
    localparam int DW = 8;

    // Alarm register: mask in the top bit, BCD value below it
    typedef struct packed {
        logic       mask;
        logic [6:0] bcd;
    } alarm_t;

    // Status byte bit positions (software-visible layout)
    localparam int FB_WDF  = 7;
    localparam int FB_AF   = 6;
    localparam int FB_PF   = 5;
    localparam int FB_OSC  = 4;
    localparam int FB_CAL  = 2;
    localparam int FB_WEN  = 1;
    localparam int FB_SNAP = 0;
endpackage

// File: rtl/rtcaf_field_cmp.sv
// Module: compares one BCD time field with its alarm register.
// Assumes the time field's top bit carries no BCD value and is ignored.
module rtcaf_field_cmp
    import rtcaf_pkg::*;
(
    input  alarm_t     alarm,
    input  logic [7:0] cur,
    output logic       hit,
    output logic       active
);
    // Field is satisfied when masked or when its value matches
    always_comb begin
        active = ~alarm.mask;
        hit    = alarm.mask | (alarm.bcd == cur[6:0]);
    end
endmodule

// File: rtl/rtcaf_flag_reg.sv
// Module: status byte holding sticky event flags and control bits.
// Assumes set strobes are single-cycle; set beats a same-cycle clear.
module rtcaf_flag_reg
    import rtcaf_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_wdf,
    input  logic          set_af,
    input  logic          set_pf,
    input  logic          set_osc,
    input  logic          rd_clr,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] flags
);
    logic wdf_q, af_q, pf_q, osc_q, cal_q, wen_q, snap_q;

    // Update flags: events set, reads clear, host writes only the controls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdf_q  <= 1'b0;
            af_q   <= 1'b0;
            pf_q   <= 1'b0;
            osc_q  <= 1'b0;
            cal_q  <= 1'b0;
            wen_q  <= 1'b0;
            snap_q <= 1'b0;
        end else begin
            wdf_q <= set_wdf | (wdf_q & ~rd_clr);
            af_q  <= set_af  | (af_q  & ~rd_clr);
            pf_q  <= set_pf  | (pf_q  & ~rd_clr);
            osc_q <= set_osc | (osc_q & ~(wr_en & ~wdata[FB_OSC]));
            if (wr_en) begin
                cal_q  <= wdata[FB_CAL];
                wen_q  <= wdata[FB_WEN];
                snap_q <= wdata[FB_SNAP];
            end
        end
    end

    // Assemble the software-visible byte; bit 3 reads 0
    always_comb begin
        flags          = '0;
        flags[FB_WDF]  = wdf_q;
        flags[FB_AF]   = af_q;
        flags[FB_PF]   = pf_q;
        flags[FB_OSC]  = osc_q;
        flags[FB_CAL]  = cal_q;
        flags[FB_WEN]  = wen_q;
        flags[FB_SNAP] = snap_q;
    end

    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !set_af) |=> !af_q);
    p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_wdf && rd_clr) |=> wdf_q);
    p_osc_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_q && !(wr_en && !wdata[FB_OSC])) |=> osc_q);
endmodule

// File: rtl/rtcaf_cal_div.sv
// Module: divides the 32.768 kHz tick down to the calibration square wave.
// Assumes tick is a one-cycle pulse; output is held low while disabled.
module rtcaf_cal_div #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    output logic sq
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;

    // Count ticks and toggle every half period
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
            sq    <= 1'b0;
        end else if (tick) begin
            if (cnt_q == CW'(HALF - 1)) begin
                cnt_q <= '0;
                sq    <= ~sq;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    p_quiet_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sq);
endmodule

// File: rtl/rtc_alarm_flags.sv
// Module: alarm matcher plus status byte with a small host register port.
// Assumes time_now is stable BCD from the external counters and that the
// host never reads and writes in the same cycle.
module rtc_alarm_flags
    import rtcaf_pkg::*;
#(
    parameter int NUM_FIELDS = 4,
    parameter int CAL_DIV    = 64,
    localparam int AW        = $clog2(NUM_FIELDS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_FIELDS*8-1:0] time_now,
    input  logic [AW-1:0]           bus_addr,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [DW-1:0]           bus_wdata,
    output logic [DW-1:0]           bus_rdata,
    input  logic                    wdog_expired,
    input  logic                    power_fail,
    input  logic                    osc_dead,
    input  logic                    tick_32k,
    output logic                    irq_out,
    output logic                    time_freeze,
    output logic                    time_snap
);
    alarm_t [NUM_FIELDS-1:0] alm_q;
    logic   [NUM_FIELDS-1:0] hit, active;
    logic                    match, match_q, flag_sel;
    logic   [DW-1:0]         flags;
    logic   [DW-1:0]         rd_mux;
    logic                    cal_sq;

    assign flag_sel = (bus_addr == AW'(NUM_FIELDS));

    // One comparator per time field
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
        rtcaf_field_cmp u_cmp (
            .alarm  (alm_q[g]),
            .cur    (time_now[g*8 +: 8]),
            .hit    (hit[g]),
            .active (active[g])
        );
    end

    assign match = (&hit) & (|active);

    // Alarm registers: writable only while the write-enable bit is set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_FIELDS; i++) alm_q[i] <= '{mask: 1'b1, bcd: 7'd0};
        end else if (bus_wr && flags[FB_WEN]) begin
            for (int i = 0; i < NUM_FIELDS; i++)
                if (bus_addr == AW'(i)) alm_q[i] <= alarm_t'(bus_wdata);
        end
    end

    // Remember last match state for rising-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match;
    end

    rtcaf_flag_reg u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_wdf (wdog_expired),
        .set_af  (match & ~match_q),
        .set_pf  (power_fail),
        .set_osc (osc_dead),
        .rd_clr  (bus_rd & flag_sel),
        .wr_en   (bus_wr & flag_sel),
        .wdata   (bus_wdata),
        .flags   (flags)
    );

    rtcaf_cal_div #(.DIV(CAL_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (flags[FB_CAL]),
        .tick  (tick_32k),
        .sq    (cal_sq)
    );

    // Select read data for the addressed register
    always_comb begin
        rd_mux = flags;
        for (int i = 0; i < NUM_FIELDS; i++)
            if (bus_addr == AW'(i)) rd_mux = alm_q[i];
    end

    // Registered read data port
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign irq_out     = flags[FB_CAL] ? cal_sq : flags[FB_AF];
    assign time_freeze = flags[FB_WEN];
    assign time_snap   = flags[FB_SNAP];

    p_alarm_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !flags[FB_WEN]) |=> $stable(alm_q));
    p_match_sets_af_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !match_q) |=> flags[FB_AF]);
endmodule

// File: tb/rtc_alarm_flags_tb.sv
module rtc_alarm_flags_tb;
    localparam int NF = 4;
    localparam int AW = $clog2(NF + 1);
    localparam logic [AW-1:0] FLAGS_A = AW'(NF);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NF*8-1:0] time_now = '0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]      bus_wdata = '0;
    logic [7:0]      bus_rdata;
    logic            wdog_expired = 1'b0, power_fail = 1'b0, osc_dead = 1'b0;
    logic            tick_32k = 1'b0;
    logic            irq_out, time_freeze, time_snap;

    int checks = 0, errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    rtc_alarm_flags #(.NUM_FIELDS(NF)) u_dut (
        .clk(clk), .rst_n(rst_n), .time_now(time_now),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdog_expired(wdog_expired), .power_fail(power_fail), .osc_dead(osc_dead),
        .tick_32k(tick_32k), .irq_out(irq_out),
        .time_freeze(time_freeze), .time_snap(time_snap)
    );

    task automatic chk(input bit ok, input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Monitor: compare read data against the scoreboard queue
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, bus_rdata, 8'h00, "unexpected read");
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(bus_rdata === e, bus_rdata, e, t);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] sec, input logic [7:0] mn);
        time_now = {16'h0000, mn, sec};
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_32k = 1'b1;
            @(negedge clk);
            tick_32k = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        rd(FLAGS_A, 8'h00, "R9 flags after reset");
        rd(0, 8'h80, "R9 alarm0 after reset");
        chk(irq_out === 1'b0, {7'd0, irq_out}, 8'h00, "R9 irq low");
        // R1 write blocked while write-enable is 0
        wr(0, 8'h15);
        rd(0, 8'h80, "R1 alarm write locked");
        // R3/R11 set write-enable
        wr(FLAGS_A, 8'h02);
        rd(FLAGS_A, 8'h02, "R3 write-enable bit");
        chk(time_freeze === 1'b1, {7'd0, time_freeze}, 8'h01, "R11 freeze out");
        wr(0, 8'h15);
        wr(1, 8'h30);
        rd(0, 8'h15, "R1 alarm0 readback");
        // R2 no match, then match
        set_time(8'h15, 8'h29);
        chk(irq_out === 1'b0, {7'd0, irq_out}, 8'h00, "R2 no match");
        set_time(8'h15, 8'h30);
        chk(irq_out === 1'b1, {7'd0, irq_out}, 8'h01, "R10 irq follows alarm");
        repeat (5) @(negedge clk);
        rd(FLAGS_A, 8'h42, "R2 alarm set");
        rd(FLAGS_A, 8'h02, "R5 alarm cleared, R2 once per match");
        // R2 new match after leaving
        set_time(8'h15, 8'h31);
        set_time(8'h15, 8'h30);
        rd(FLAGS_A, 8'h42, "R2 second match");
        // R1 mask the minutes field
        wr(1, 8'hB0);
        set_time(8'h15, 8'h11);
        rd(FLAGS_A, 8'h02, "R2 no new edge while matching");
        set_time(8'h00, 8'h11);
        set_time(8'h15, 8'h11);
        rd(FLAGS_A, 8'h42, "R1 masked field ignored");
        // R2 all fields masked: never matches
        wr(0, 8'h80);
        set_time(8'h00, 8'h00);
        set_time(8'h15, 8'h30);
        rd(FLAGS_A, 8'h02, "R2 all masked no match");
        // R4 watchdog and power-fail
        pulse(wdog_expired);
        rd(FLAGS_A, 8'h82, "R4 watchdog flag");
        rd(FLAGS_A, 8'h02, "R5 watchdog cleared");
        pulse(power_fail);
        rd(FLAGS_A, 8'h22, "R4 power-fail flag");
        rd(FLAGS_A, 8'h02, "R5 power-fail cleared");
        // R6 set and clearing read in same cycle
        exp_q.push_back(8'h02); tag_q.push_back("R6 read before set");
        bus_addr = FLAGS_A; bus_rd = 1'b1; wdog_expired = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; wdog_expired = 1'b0;
        rd(FLAGS_A, 8'h82, "R6 set wins over clear");
        rd(FLAGS_A, 8'h02, "R6 later read clears");
        // R7 read-only bits and bit 3
        wr(FLAGS_A, 8'hEA);
        rd(FLAGS_A, 8'h02, "R7 read-only bits ignore writes");
        // R8 oscillator-fail
        pulse(osc_dead);
        rd(FLAGS_A, 8'h12, "R8 osc flag set");
        rd(FLAGS_A, 8'h12, "R8 read does not clear");
        wr(FLAGS_A, 8'h12);
        rd(FLAGS_A, 8'h12, "R8 write 1 keeps");
        wr(FLAGS_A, 8'h02);
        rd(FLAGS_A, 8'h02, "R8 write 0 clears");
        wr(FLAGS_A, 8'h10);
        rd(FLAGS_A, 8'h00, "R8 write 1 does not set");
        wr(FLAGS_A, 8'h02);
        // R11 snapshot control
        wr(FLAGS_A, 8'h03);
        chk(time_snap === 1'b1, {7'd0, time_snap}, 8'h01, "R11 snap out");
        wr(FLAGS_A, 8'h02);
        chk(time_snap === 1'b0, {7'd0, time_snap}, 8'h00, "R11 snap off");
        // R10 calibration wave
        wr(FLAGS_A, 8'h06);
        chk(irq_out === 1'b0, {7'd0, irq_out}, 8'h00, "R10 wave starts low");
        ticks(31);
        chk(irq_out === 1'b0, {7'd0, irq_out}, 8'h00, "R10 low after 31 ticks");
        ticks(1);
        chk(irq_out === 1'b1, {7'd0, irq_out}, 8'h01, "R10 high after 32 ticks");
        ticks(31);
        chk(irq_out === 1'b1, {7'd0, irq_out}, 8'h01, "R10 high after 63 ticks");
        ticks(1);
        chk(irq_out === 1'b0, {7'd0, irq_out}, 8'h00, "R10 low after 64 ticks");
        ticks(32);
        wr(FLAGS_A, 8'h02);
        chk(irq_out === 1'b0, {7'd0, irq_out}, 8'h00, "R10 back to alarm flag");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) chk(1'b0, 8'(exp_q.size()), 8'h00, "scoreboard drained");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule